// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is a hardware master that loads a target FPGA through its byte-wide slave parallel configuration port. After a start pulse it pulses the target's program pin, waits for the target to clear its configuration memory, and clocks configuration bytes from a valid/ready stream into the port, one byte per configuration-clock cycle. While writing it watches the target's INIT and DONE pins, and optionally its BUSY pin. At the end it checks that the target has come up, and it reports the outcome as a status code.

A second mode reads bytes back from the same port into an output stream. The total byte count and the mode are latched when the start pulse is accepted. Every wait has its own timeout, counted in milliseconds from a free-running prescaler. The configuration-clock half period and the program pulse width are counted in system clock cycles.

Top module: `fpga_cfg_loader`

## Requirements
- R1: On start in write mode, `tgt_prog_n` goes low and stays low for at least PROG_W cycles and until `tgt_init_n` reads low. If `tgt_init_n` does not go low in time, the run ends with status 3.
- R2: After program release, `tgt_cclk` is high and the block waits for `tgt_init_n` high. If that times out, the run ends with status 4.
- R3: `tgt_sel_n` and `tgt_wr_n` go low only after `tgt_init_n` has been seen high. Each accepted byte (`s_valid` and `s_ready` both high) is driven on `tgt_dout` for at least HALF cycles before `tgt_cclk` falls. The clock then stays low for HALF cycles and high for HALF cycles, and bytes reach the target in stream order.
- R4: If `tgt_init_n` is low at the check before a byte, writing stops and `tgt_sel_n` and `tgt_wr_n` return high. Status becomes 5 and `err_offset` holds the number of bytes already clocked.
- R5: If `tgt_done` is high at the check before a byte, no further bytes are accepted and the block moves to the final check.
- R6: With `busy_chk_en` high, the block stalls after each clock rise while `tgt_busy` is high, and ends with status 6 if the stall outlasts T_BUSY_MS. With `busy_chk_en` low, `tgt_busy` has no effect.
- R7: After the last byte, `tgt_sel_n` and `tgt_wr_n` go high. The run ends with status 2 once `tgt_done` and `tgt_init_n` are both high, and with status 7 on timeout.
- R8: In read mode `tgt_sel_n` is low, `tgt_wr_n` is high and `tgt_prog_n` stays high. For each byte, `tgt_cclk` goes low and then high, and `tgt_din` is sampled HALF cycles after the rise. The sample appears on `m_data` with a one-cycle `m_valid`. Afterwards `tgt_sel_n` goes high and exactly one more clock rise follows, then status becomes 2.
- R9: Status is 0 after reset and 1 while a run is active. The final code holds until the next start. A start pulse during a run is ignored.
- R10: A timeout fires when more than its limit of millisecond ticks has passed since the wait began. One tick occurs every TICK_DIV cycles.
- R11: A byte count of 0 sends no bytes in write mode and goes straight to the final check. In read mode it produces no `m_valid` and only the deselect clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| rd_mode | input | 1 | 1 = read back, 0 = configure |
| busy_chk_en | input | 1 | Enable stalling on the target busy pin |
| byte_count | input | CNT_W | Number of bytes in the run |
| s_data | input | 8 | Configuration byte stream data |
| s_valid | input | 1 | Stream byte available |
| s_ready | output | 1 | Byte taken this cycle |
| m_data | output | 8 | Read-back byte |
| m_valid | output | 1 | One-cycle strobe for `m_data` |
| tgt_prog_n | output | 1 | Target program pin, active low |
| tgt_sel_n | output | 1 | Target chip select, active low |
| tgt_wr_n | output | 1 | Target write strobe, active low |
| tgt_cclk | output | 1 | Target configuration clock |
| tgt_dout | output | 8 | Data toward the target |
| tgt_doe | output | 1 | Output enable for `tgt_dout` |
| tgt_din | input | 8 | Data from the target |
| tgt_init_n | input | 1 | Target init/error pin, low = clearing or error |
| tgt_done | input | 1 | Target done pin |
| tgt_busy | input | 1 | Target busy pin |
| status | output | 4 | 0 idle, 1 running, 2 success, 3 init-low timeout, 4 init-high timeout, 5 config error, 6 busy timeout, 7 done timeout |
| err_offset | output | CNT_W | Bytes clocked before a config error |

## Verification
The bench builds the block with TICK_DIV=8, HALF=2, PROG_W=6 and timeouts of 4, 3 and 5 ms, with CNT_W=8. At these values each timeout expires within a few dozen cycles, so every failure code can be reached directly, and the expiry window itself can be measured against its tick bounds. A behavioural target model answers the program pulse and records clocked bytes. It can inject an INIT error or an early DONE at a chosen byte, and it can hold BUSY high or toggle it at random.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_RUN       = 4'd1,
    ST_OK        = 4'd2,
    ST_TO_INITLO = 4'd3,
    ST_TO_INITHI = 4'd4,
    ST_CFG_ERR   = 4'd5,
    ST_TO_BUSY   = 4'd6,
    ST_TO_DONE   = 4'd7
  } ldr_status_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PROG,
    S_REL,
    S_SEL,
    S_CHK,
    S_SETUP,
    S_LOW,
    S_HIGH,
    S_END,
    S_RB_SEL,
    S_RB_LOW,
    S_RB_HIGH,
    S_RB_DLOW,
    S_RB_DHIGH
  } ldr_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen #(
  parameter int unsigned DIV = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV > 1) begin : g_div
      localparam int unsigned W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == LAST);

      assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_every
      assign tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/cfg_dwell_cnt.sv
module cfg_dwell_cnt #(
  parameter int unsigned MAXC = 80
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart,
  output logic [$clog2(MAXC+1)-1:0]  count
);

  localparam int unsigned W = $clog2(MAXC + 1);
  localparam logic [W-1:0] CAP = W'(MAXC);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = restart || (cnt_q != CAP);
    cnt_d  = restart ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_dwell_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));

endmodule

// File: rtl/cfg_ms_timer.sv
module cfg_ms_timer #(
  parameter int unsigned MAX_MS = 500
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        restart,
  input  logic                        tick,
  input  logic [$clog2(MAX_MS+2)-1:0] limit,
  output logic                        expired
);

  localparam int unsigned W = $clog2(MAX_MS + 2);
  localparam logic [W-1:0] CAP = W'(MAX_MS + 1);

  logic [W-1:0] ms_q, ms_d;
  logic         ms_en;

  always_comb begin
    ms_en = restart || (tick && (ms_q != CAP));
    ms_d  = restart ? '0 : ms_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ms_q <= '0;
    else if (ms_en) ms_q <= ms_d;
  end

  assign expired = (ms_q > limit);

  assert_timer_fresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfg_ldr_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned TICK_DIV  = 250000,
  parameter int unsigned HALF      = 2,
  parameter int unsigned PROG_W    = 80,
  parameter int unsigned T_INIT_MS = 500,
  parameter int unsigned T_BUSY_MS = 5,
  parameter int unsigned T_DONE_MS = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_mode,
  input  logic             busy_chk_en,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic [7:0]       m_data,
  output logic             m_valid,
  output logic             tgt_prog_n,
  output logic             tgt_sel_n,
  output logic             tgt_wr_n,
  output logic             tgt_cclk,
  output logic [7:0]       tgt_dout,
  output logic             tgt_doe,
  input  logic [7:0]       tgt_din,
  input  logic             tgt_init_n,
  input  logic             tgt_done,
  input  logic             tgt_busy,
  output logic [3:0]       status,
  output logic [CNT_W-1:0] err_offset
);

  localparam int unsigned DMAX  = umax(PROG_W, HALF);
  localparam int unsigned DW    = $clog2(DMAX + 1);
  localparam int unsigned MSMAX = umax(T_INIT_MS, umax(T_BUSY_MS, T_DONE_MS));
  localparam int unsigned TW    = $clog2(MSMAX + 2);
  localparam logic [DW-1:0] HALF_LAST = DW'(HALF - 1);
  localparam logic [DW-1:0] PROG_LAST = DW'(PROG_W - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  ldr_state_e  state_q, state_d;
  ldr_status_e status_q, status_d;
  logic [CNT_W-1:0] idx_q, idx_d, cnt_q, err_q;
  logic rd_q, ben_q;
  logic [7:0] dout_q, mdata_q;
  logic mvalid_q;

  logic cfg_ld, dout_ld, err_ld, samp, ready_c;
  logic restart, tick, tm_exp, half_ok, prog_ok, rb_last;
  logic [DW-1:0] dwell;
  logic [TW-1:0] lim;

  cfg_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_ni), .tick(tick));

  cfg_dwell_cnt #(.MAXC(DMAX)) u_dwell (
    .clk(clk), .rst_n(rst_ni), .restart(restart), .count(dwell));

  cfg_ms_timer #(.MAX_MS(MSMAX)) u_timer (
    .clk(clk), .rst_n(rst_ni), .restart(restart), .tick(tick),
    .limit(lim), .expired(tm_exp));

  assign half_ok = (dwell >= HALF_LAST);
  assign prog_ok = (dwell >= PROG_LAST);
  assign rb_last = ((idx_q + CNT_W'(1)) == cnt_q);
  assign restart = (state_d != state_q);

  // timeout limit of the wait in progress
  always_comb begin
    case (state_q)
      S_PROG, S_REL: lim = TW'(T_INIT_MS);
      S_HIGH:        lim = TW'(T_BUSY_MS);
      S_END:         lim = TW'(T_DONE_MS);
      default:       lim = TW'(MSMAX);
    endcase
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    idx_d    = idx_q;
    cfg_ld   = 1'b0;
    dout_ld  = 1'b0;
    err_ld   = 1'b0;
    samp     = 1'b0;
    ready_c  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          cfg_ld   = 1'b1;
          status_d = ST_RUN;
          idx_d    = '0;
          state_d  = rd_mode ? S_RB_SEL : S_PROG;
        end
      end
      S_PROG: begin
        if (prog_ok && !tgt_init_n) state_d = S_REL;
        else if (tm_exp) begin
          status_d = ST_TO_INITLO;
          state_d  = S_IDLE;
        end
      end
      S_REL: begin
        if (tgt_init_n) state_d = S_SEL;
        else if (tm_exp) begin
          status_d = ST_TO_INITHI;
          state_d  = S_IDLE;
        end
      end
      S_SEL: state_d = S_CHK;
      S_CHK: begin
        if ((idx_q == cnt_q) || tgt_done) state_d = S_END;
        else if (!tgt_init_n) begin
          err_ld   = 1'b1;
          status_d = ST_CFG_ERR;
          state_d  = S_IDLE;
        end else begin
          ready_c = 1'b1;
          if (s_valid) begin
            dout_ld = 1'b1;
            state_d = S_SETUP;
          end
        end
      end
      S_SETUP: if (half_ok) state_d = S_LOW;
      S_LOW:   if (half_ok) state_d = S_HIGH;
      S_HIGH: begin
        if (ben_q && tgt_busy) begin
          if (tm_exp) begin
            status_d = ST_TO_BUSY;
            state_d  = S_IDLE;
          end
        end else if (half_ok) begin
          idx_d   = idx_q + CNT_W'(1);
          state_d = S_CHK;
        end
      end
      S_END: begin
        if (tgt_done && tgt_init_n) begin
          status_d = ST_OK;
          state_d  = S_IDLE;
        end else if (tm_exp) begin
          status_d = ST_TO_DONE;
          state_d  = S_IDLE;
        end
      end
      S_RB_SEL: if (half_ok) state_d = (cnt_q == '0) ? S_RB_DLOW : S_RB_LOW;
      S_RB_LOW: if (half_ok) state_d = S_RB_HIGH;
      S_RB_HIGH: begin
        if (half_ok) begin
          samp    = 1'b1;
          idx_d   = idx_q + CNT_W'(1);
          state_d = rb_last ? S_RB_DLOW : S_RB_LOW;
        end
      end
      S_RB_DLOW: if (half_ok) state_d = S_RB_DHIGH;
      S_RB_DHIGH: begin
        if (half_ok) begin
          status_d = ST_OK;
          state_d  = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      status_q <= ST_IDLE;
      idx_q    <= '0;
      mvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      idx_q    <= idx_d;
      mvalid_q <= samp;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rd_q  <= 1'b0;
      ben_q <= 1'b0;
    end else if (cfg_ld) begin
      cnt_q <= byte_count;
      rd_q  <= rd_mode;
      ben_q <= busy_chk_en;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      dout_q <= '0;
    else if (dout_ld) dout_q <= s_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   mdata_q <= '0;
    else if (samp) mdata_q <= tgt_din;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                err_q <= '0;
    else if (cfg_ld || err_ld)  err_q <= cfg_ld ? '0 : idx_q;
  end

  // pin decode from the registered state
  always_comb begin
    tgt_prog_n = 1'b1;
    tgt_sel_n  = 1'b1;
    tgt_wr_n   = 1'b1;
    tgt_cclk   = 1'b1;
    tgt_doe    = 1'b0;
    case (state_q)
      S_IDLE:  tgt_cclk = 1'b0;
      S_PROG: begin
        tgt_prog_n = 1'b0;
        tgt_cclk   = 1'b0;
      end
      S_SEL, S_CHK, S_SETUP, S_HIGH: begin
        tgt_sel_n = 1'b0;
        tgt_wr_n  = 1'b0;
        tgt_doe   = 1'b1;
      end
      S_LOW: begin
        tgt_sel_n = 1'b0;
        tgt_wr_n  = 1'b0;
        tgt_doe   = 1'b1;
        tgt_cclk  = 1'b0;
      end
      S_RB_SEL, S_RB_HIGH: tgt_sel_n = 1'b0;
      S_RB_LOW: begin
        tgt_sel_n = 1'b0;
        tgt_cclk  = 1'b0;
      end
      S_RB_DLOW: tgt_cclk = 1'b0;
      default: ;
    endcase
  end

  assign s_ready    = ready_c;
  assign tgt_dout   = dout_q;
  assign m_data     = mdata_q;
  assign m_valid    = mvalid_q;
  assign status     = status_q;
  assign err_offset = err_q;

  // checks beside the logic they guard
  assert_prog_width_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_PROG && state_d == S_REL) |-> (dwell >= PROG_LAST));

  assert_sel_after_init_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(tgt_sel_n) && !rd_q) |-> $past(tgt_init_n));

  assert_init_error_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_CHK && idx_q != cnt_q && !tgt_done && !tgt_init_n)
      |=> (status_q == ST_CFG_ERR));

  assert_busy_stall_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_HIGH && ben_q && tgt_busy) |=> $stable(idx_q));

  assert_rb_sample_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    m_valid |-> (rd_q && $past(tgt_cclk) && !$past(tgt_sel_n)));

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == S_IDLE && !start) |=> $stable(status_q));

endmodule

// File: tb/fpga_cfg_loader_test.sv
module fpga_cfg_loader_test;

  localparam int CW = 8, DIV = 8, HP = 2, PW = 6, TI = 4, TB = 3, TD = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, rd_mode, busy_chk_en, s_valid, s_ready, m_valid;
  logic [CW-1:0] byte_count, err_offset;
  logic [7:0] s_data, m_data, tgt_dout, tgt_din;
  logic tgt_prog_n, tgt_sel_n, tgt_wr_n, tgt_cclk, tgt_doe;
  logic tgt_init_n, tgt_done, tgt_busy;
  logic [3:0] status;

  fpga_cfg_loader #(.CNT_W(CW), .TICK_DIV(DIV), .HALF(HP), .PROG_W(PW),
    .T_INIT_MS(TI), .T_BUSY_MS(TB), .T_DONE_MS(TD)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
    .busy_chk_en(busy_chk_en), .byte_count(byte_count), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .m_data(m_data), .m_valid(m_valid),
    .tgt_prog_n(tgt_prog_n), .tgt_sel_n(tgt_sel_n), .tgt_wr_n(tgt_wr_n),
    .tgt_cclk(tgt_cclk), .tgt_dout(tgt_dout), .tgt_doe(tgt_doe),
    .tgt_din(tgt_din), .tgt_init_n(tgt_init_n), .tgt_done(tgt_done),
    .tgt_busy(tgt_busy), .status(status), .err_offset(err_offset));

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // target model configuration
  bit m_resp, m_rel, m_brand, m_bstuck, rd_run;
  int m_err_at, m_done_at;
  // target model state
  int rel_cnt, nbytes, rk, dsel, plow, last_plow, stab, min_setup, early_cs, nrx;
  bit errl, rel_seen;
  logic pc, pcs;
  logic [7:0] pd;
  logic [7:0] rec [0:255];
  logic [7:0] tx  [0:255];
  logic [7:0] rx  [0:255];

  function automatic logic [7:0] rbf(input int k);
    return 8'(k * 37 + 5);
  endfunction

  assign tgt_din = rbf(rk);

  always @(negedge clk) begin
    if (!tgt_prog_n) begin
      if (m_resp) tgt_init_n = 1'b0;
      tgt_done = 1'b0;
      rel_cnt = 0; nbytes = 0; errl = 0; rel_seen = 0;
      plow++;
    end else begin
      if (plow > 0) begin last_plow = plow; plow = 0; end
      if (!tgt_init_n && m_rel && !errl) begin
        rel_cnt++;
        if (rel_cnt >= 3) begin
          tgt_init_n = 1'b1;
          if (m_done_at == 0) tgt_done = 1'b1;
        end
      end
      if (tgt_init_n) rel_seen = 1;
    end
    if (!tgt_sel_n && !tgt_wr_n && !rel_seen) early_cs++;
    if (tgt_cclk && !pc) begin
      if (!tgt_sel_n && !tgt_wr_n) begin
        rec[nbytes[7:0]] = tgt_dout;
        nbytes++;
        if (nbytes == m_err_at) begin tgt_init_n = 1'b0; errl = 1; end
        if (nbytes == m_done_at) tgt_done = 1'b1;
      end else if (!tgt_sel_n && !pcs && tgt_wr_n) rk++;
      else if (tgt_sel_n && rd_run) dsel++;
    end
    if (!tgt_cclk && pc && !tgt_wr_n && stab < min_setup) min_setup = stab;
    if (tgt_dout != pd) stab = 1; else stab++;
    if (tgt_sel_n) rk = 0;
    if (m_bstuck) tgt_busy = !tgt_sel_n && !tgt_wr_n;
    else if (m_brand && !tgt_sel_n && !tgt_wr_n) tgt_busy = ($urandom % 3 == 0);
    else tgt_busy = 1'b0;
    pc = tgt_cclk; pcs = tgt_sel_n; pd = tgt_dout;
  end

  always @(negedge clk) if (m_valid) begin rx[nrx[7:0]] = m_data; nrx++; end

  task automatic setm(input bit resp, input bit rel, input bit brand, input bit bstuck,
                      input int err_at, input int done_at);
    m_resp = resp; m_rel = rel; m_brand = brand; m_bstuck = bstuck;
    m_err_at = err_at; m_done_at = done_at;
    min_setup = 1000; early_cs = 0; dsel = 0; nrx = 0; last_plow = 0;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      s_data = tx[i];
      s_valid = 1'b1;
      while (1) begin
        @(negedge clk); #1;
        if (s_ready || status != 4'd1) break;
      end
      if (status != 4'd1) break;
      @(posedge clk); #1;
      s_valid = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  task automatic wait_end(output int k);
    k = 0;
    while (status == 4'd1 && k < 4000) begin @(negedge clk); k++; end
  endtask

  task automatic kick(input bit rd, input int n, input bit ben);
    for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
    rd_run = rd;
    @(negedge clk);
    rd_mode = rd; byte_count = CW'(n); busy_chk_en = ben; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input bit rd, input int n, input bit ben);
    int k;
    kick(rd, n, ben);
    fork
      feed(rd ? 0 : n);
      wait_end(k);
    join
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_bytes(input int n, input string tag);
    for (int i = 0; i < n; i++)
      chk(rec[i] == tx[i], tag, int'(rec[i]), int'(tx[i]));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b0; rd_mode = 1'b0; busy_chk_en = 1'b0;
    byte_count = '0; s_data = '0; s_valid = 1'b0;
    tgt_init_n = 1'b1; tgt_done = 1'b0; tgt_busy = 1'b0;
    pc = 1'b0; pcs = 1'b1; pd = '0; rk = 0; plow = 0; stab = 0; nbytes = 0; rd_run = 0;
    setm(1, 1, 0, 0, -1, 12);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    chk(status == 4'd0, "R9 reset status", int'(status), 0);
    chk(tgt_prog_n && tgt_sel_n && tgt_wr_n, "R9 reset pins", int'({tgt_prog_n, tgt_sel_n, tgt_wr_n}), 7);
    chk(!s_ready && !m_valid, "R9 reset stream", int'({s_ready, m_valid}), 0);

    // R1 R3 R7: plain write
    setm(1, 1, 0, 0, -1, 12);
    run(0, 12, 0);
    chk(status == 4'd2, "R7 write success", int'(status), 2);
    chk(nbytes == 12, "R3 byte count", nbytes, 12);
    chk_bytes(12, "R3 byte data");
    chk(last_plow >= PW, "R1 prog width", last_plow, PW);
    chk(min_setup >= HP, "R3 setup cycles", min_setup, HP);
    chk(early_cs == 0, "R3 select before init high", early_cs, 0);
    chk(tgt_sel_n && tgt_wr_n, "R7 deselect at end", int'({tgt_sel_n, tgt_wr_n}), 3);

    // R6: random busy with checking on
    setm(1, 1, 1, 0, -1, 20);
    run(0, 20, 1);
    chk(status == 4'd2, "R6 busy random success", int'(status), 2);
    chk_bytes(20, "R6 busy random data");

    // R6: busy held high but checking off
    setm(1, 1, 0, 1, -1, 9);
    run(0, 9, 0);
    chk(status == 4'd2, "R6 busy ignored status", int'(status), 2);
    chk(nbytes == 9, "R6 busy ignored bytes", nbytes, 9);

    // R6: busy stuck with checking on
    setm(1, 1, 0, 1, -1, 9);
    run(0, 9, 1);
    chk(status == 4'd6, "R6 busy timeout", int'(status), 6);
    chk(nbytes == 1, "R6 stalled after first byte", nbytes, 1);

    // R1 R10: target never pulls init low; measure expiry window
    setm(0, 1, 0, 0, -1, 5);
    kick(0, 5, 0);
    wait_end(k);
    chk(status == 4'd3, "R1 init-low timeout", int'(status), 3);
    chk(k >= TI * DIV && k <= (TI + 1) * DIV + 2, "R10 timeout window", k, (TI + 1) * DIV);
    chk(tgt_prog_n, "R1 prog released after abort", int'(tgt_prog_n), 1);
    repeat (3) @(negedge clk);

    // R2: target never releases init
    setm(1, 0, 0, 0, -1, 5);
    run(0, 5, 0);
    chk(status == 4'd4, "R2 init-high timeout", int'(status), 4);
    tgt_init_n = 1'b1;

    // R4: config error after byte 5
    setm(1, 1, 0, 0, 5, 10);
    run(0, 10, 0);
    chk(status == 4'd5, "R4 config error status", int'(status), 5);
    chk(err_offset == 5, "R4 error offset", int'(err_offset), 5);
    chk(nbytes == 5, "R4 writing stopped", nbytes, 5);
    chk(tgt_sel_n && tgt_wr_n, "R4 deselect on error", int'({tgt_sel_n, tgt_wr_n}), 3);
    tgt_init_n = 1'b1;

    // R5: done early after 4 of 10
    setm(1, 1, 0, 0, -1, 4);
    run(0, 10, 0);
    chk(status == 4'd2, "R5 early done status", int'(status), 2);
    chk(nbytes == 4, "R5 early done bytes", nbytes, 4);

    // R7: done never rises
    setm(1, 1, 0, 0, -1, 255);
    run(0, 6, 0);
    chk(status == 4'd7, "R7 done timeout", int'(status), 7);

    // R8: read back 6 bytes
    setm(1, 1, 0, 0, -1, 0);
    run(1, 6, 0);
    chk(status == 4'd2, "R8 readback status", int'(status), 2);
    chk(nrx == 6, "R8 readback count", nrx, 6);
    for (int i = 0; i < 6; i++)
      chk(rx[i] == rbf(i + 1), "R8 readback data", int'(rx[i]), int'(rbf(i + 1)));
    chk(dsel == 1, "R8 deselect clock", dsel, 1);
    chk(last_plow == 0, "R8 no program pulse", last_plow, 0);

    // R11: zero-length runs
    setm(1, 1, 0, 0, -1, 0);
    run(0, 0, 0);
    chk(status == 4'd2, "R11 zero write status", int'(status), 2);
    chk(nbytes == 0, "R11 zero write bytes", nbytes, 0);
    setm(1, 1, 0, 0, -1, 0);
    run(1, 0, 0);
    chk(status == 4'd2 && nrx == 0, "R11 zero readback", nrx, 0);
    chk(dsel == 1, "R11 zero readback deselect", dsel, 1);

    // R9: start ignored while running, status held afterwards
    setm(1, 1, 0, 0, -1, 8);
    kick(0, 8, 0);
    fork
      feed(8);
      wait_end(k);
      begin
        repeat (10) @(negedge clk);
        chk(status == 4'd1, "R9 running status", int'(status), 1);
        rd_mode = 1'b1; byte_count = 8'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rd_mode = 1'b0;
      end
    join
    chk(status == 4'd2, "R9 restart ignored status", int'(status), 2);
    chk(nbytes == 8, "R9 restart ignored bytes", nbytes, 8);
    chk_bytes(8, "R9 restart ignored data");
    repeat (50) @(negedge clk);
    chk(status == 4'd2, "R9 status held", int'(status), 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule